// File: doc/BRIEF.md
# Multi-operation condition code generator

This block turns the outcome of an integer operation into a 2-bit condition code. A single operation selector picks one of many rules: signed or unsigned ordering of two operands, a signed test of a value against zero, a nonzero test, the overflow and carry rules of signed and unsigned addition and subtraction, and the special cases of absolute value, negative absolute value and two's-complement negation. Each rule comes in a narrow form that uses only the low half of every operand and a full-width form. Four selector values do no computation: the selector itself is the code.

The unit is combinational up to a single output register. Operands arrive with a valid strobe. The code and an illegal-selector flag are captured on the clock edge where the strobe is high, and they hold their values between strobes. Operand A and operand B are the two inputs of the operation. Operand R is the value that the operation produced.

Top module: `cc_gen`

## Requirements
- R1: Selector values 0 to 3 give a code equal to the low two selector bits, and the operands are ignored.
- R2: Selectors 6 (narrow) and 7 (full) order A against B as signed two's-complement values. Selectors 8 (narrow) and 9 (full) order them by unsigned magnitude. The code is 0 when they are equal, 1 when A is lower and 2 when A is higher.
- R3: Selectors 4 (narrow) and 5 (full) order R as a signed value against zero, with the same codes as R2.
- R4: Selector 10 gives 0 when all bits of R are zero and 1 otherwise.
- R5: Selectors 11 (narrow) and 12 (full) give 3 on signed add overflow, which is A>0, B>0 and R<0, or A<0, B<0 and R>0. Otherwise the code is 0 for R zero, 1 for R negative and 2 for R positive.
- R6: Selectors 15 (narrow) and 16 (full) give 3 on signed subtract overflow, which is A>0, B<0 and R<0, or A<0, B>0 and R>0. Otherwise the codes are as in R5.
- R7: Selectors 13 (narrow) and 14 (full) form the code as {carry, R nonzero}. Carry is set when R is below A or below B as unsigned values.
- R8: Selectors 17 (narrow) and 18 (full) form the code as {no borrow, R nonzero}. No borrow is set when A is at least B as unsigned values.
- R9: Selectors 19 and 20 (absolute value) give 3 when R is the most negative value, 0 when R is zero and 2 otherwise. Selectors 21 and 22 (negative absolute value) give 0 when R is zero and 1 otherwise. In each pair the lower selector is the narrow form.
- R10: Selectors 23 (narrow) and 24 (full) apply the negation rule: 3 for the most negative value, otherwise 0, 1 or 2 for R zero, negative or positive.
- R11: The narrow forms use only the low half of each operand. The most negative narrow value is 0x80000000, and the upper operand bits have no effect.
- R12: Selectors 25 to 31 set the illegal flag and give code 0. Every other selector clears the flag.
- R13: Reset clears the code and the flag. Both update one cycle after a high valid strobe and keep their values while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and selector are valid this cycle |
| op | input | OP_W (5) | Operation selector |
| opnd_a | input | DATA_W (64) | First operand |
| opnd_b | input | DATA_W (64) | Second operand |
| opnd_r | input | DATA_W (64) | Result value of the operation |
| cc | output | 2 | Registered condition code |
| illegal | output | 1 | Registered illegal-selector flag |

## Verification
The bench builds the block with DATA_W=64 and OP_W=5. With a 32-bit narrow lane, the most negative narrow value and the junk in the upper half are separate cases. A 5-bit selector places the illegal codes 25 to 31 inside the random range. Random operands come from a pool of corner values, and R is often the true sum or difference of A and B. This gives overflow, carry and borrow cases in both widths as well as cases where R is unrelated to A and B.

// File: rtl/cc_gen_pkg.sv
package cc_gen_pkg;
   localparam int CC_SEL_PASS_LAST = 3;
   localparam int CC_SEL_TSTZ_N    = 4;
   localparam int CC_SEL_TSTZ_F    = 5;
   localparam int CC_SEL_CMPS_N    = 6;
   localparam int CC_SEL_CMPS_F    = 7;
   localparam int CC_SEL_CMPU_N    = 8;
   localparam int CC_SEL_CMPU_F    = 9;
   localparam int CC_SEL_NZ        = 10;
   localparam int CC_SEL_ADDS_N    = 11;
   localparam int CC_SEL_ADDS_F    = 12;
   localparam int CC_SEL_ADDU_N    = 13;
   localparam int CC_SEL_ADDU_F    = 14;
   localparam int CC_SEL_SUBS_N    = 15;
   localparam int CC_SEL_SUBS_F    = 16;
   localparam int CC_SEL_SUBU_N    = 17;
   localparam int CC_SEL_SUBU_F    = 18;
   localparam int CC_SEL_ABS_N     = 19;
   localparam int CC_SEL_ABS_F     = 20;
   localparam int CC_SEL_NABS_N    = 21;
   localparam int CC_SEL_NABS_F    = 22;
   localparam int CC_SEL_NEG_N     = 23;
   localparam int CC_SEL_NEG_F     = 24;
   localparam int CC_SEL_LAST      = 24;

   typedef struct packed {
      logic [1:0] cmp_s;
      logic [1:0] cmp_u;
      logic [1:0] tstz;
      logic [1:0] add_s;
      logic [1:0] add_u;
      logic [1:0] sub_s;
      logic [1:0] sub_u;
      logic [1:0] abs_v;
      logic [1:0] nabs_v;
      logic [1:0] neg_v;
   } lane_codes_t;
endpackage

// File: rtl/cc_order_unit.sv
module cc_order_unit #(
   parameter int W = 64
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [1:0]   code_s,
   output logic [1:0]   code_u
);
   logic same, below_s, below_u;

   assign same    = (x == y);
   assign below_s = ($signed(x) < $signed(y));
   assign below_u = (x < y);

   always_comb begin
      if (same)         code_s = 2'd0;
      else if (below_s) code_s = 2'd1;
      else              code_s = 2'd2;
      if (same)         code_u = 2'd0;
      else if (below_u) code_u = 2'd1;
      else              code_u = 2'd2;
   end

   // R2
   always_comb begin
      if (same) begin
         equal_zero_chk: assert (code_s == 2'd0 && code_u == 2'd0);
      end
   end
endmodule

// File: rtl/cc_arith_unit.sv
module cc_arith_unit #(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] r,
   output logic [1:0]   add_s,
   output logic [1:0]   add_u,
   output logic [1:0]   sub_s,
   output logic [1:0]   sub_u
);
   logic a_pos, a_neg, b_pos, b_neg, r_pos, r_neg, r_nz;
   logic ovf_add, ovf_sub, carry, no_borrow;
   logic [1:0] sign_code;

   assign a_neg = a[W-1];
   assign b_neg = b[W-1];
   assign r_neg = r[W-1];
   assign a_pos = !a[W-1] && (|a);
   assign b_pos = !b[W-1] && (|b);
   assign r_nz  = |r;
   assign r_pos = !r[W-1] && r_nz;

   assign ovf_add   = (a_pos && b_pos && r_neg) || (a_neg && b_neg && r_pos);
   assign ovf_sub   = (a_pos && b_neg && r_neg) || (a_neg && b_pos && r_pos);
   assign carry     = (r < a) || (r < b);
   assign no_borrow = (a >= b);

   always_comb begin
      if (!r_nz)      sign_code = 2'd0;
      else if (r_neg) sign_code = 2'd1;
      else            sign_code = 2'd2;
      add_s = ovf_add ? 2'd3 : sign_code;
      sub_s = ovf_sub ? 2'd3 : sign_code;
      add_u = {carry, r_nz};
      sub_u = {no_borrow, r_nz};
   end

   // R5
   always_comb begin
      if (!r_nz) begin
         zero_no_overflow_chk: assert (add_s == 2'd0 && sub_s == 2'd0);
      end
   end
endmodule

// File: rtl/cc_unary_unit.sv
module cc_unary_unit #(
   parameter int W = 64
) (
   input  logic [W-1:0] r,
   output logic [1:0]   abs_v,
   output logic [1:0]   nabs_v,
   output logic [1:0]   neg_v
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

   logic is_min, is_zero;

   assign is_min  = (r == MOST_NEG);
   assign is_zero = (r == '0);

   always_comb begin
      if (is_min)       abs_v = 2'd3;
      else if (is_zero) abs_v = 2'd0;
      else              abs_v = 2'd2;
      nabs_v = is_zero ? 2'd0 : 2'd1;
      if (is_min)       neg_v = 2'd3;
      else if (r[W-1])  neg_v = 2'd1;
      else if (is_zero) neg_v = 2'd0;
      else              neg_v = 2'd2;
   end

   // R10
   always_comb begin
      if (is_min) begin
         most_neg_chk: assert (abs_v == 2'd3 && neg_v == 2'd3 && nabs_v == 2'd1);
      end
   end
endmodule

// File: rtl/cc_gen.sv
module cc_gen #(
   parameter int DATA_W = 64,
   parameter int OP_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] opnd_r,
   output logic [1:0]        cc,
   output logic              illegal
);
   import cc_gen_pkg::*;

   localparam int HALF_W = DATA_W / 2;
   localparam int LANES  = 2;

   generate
      if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("cc_gen: DATA_W must be even and at least 8");
      end
      if (OP_W < 5) begin : g_bad_op
         $error("cc_gen: OP_W must hold selectors up to 31");
      end
   endgenerate

   lane_codes_t lane [LANES];

   // lane 0 is the narrow form, lane 1 the full width
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int LW = (g == 0) ? HALF_W : DATA_W;

      cc_order_unit #(.W(LW)) u_cmp (
         .x(opnd_a[LW-1:0]), .y(opnd_b[LW-1:0]),
         .code_s(lane[g].cmp_s), .code_u(lane[g].cmp_u)
      );

      logic [1:0] tstz_u_unused;
      cc_order_unit #(.W(LW)) u_tstz (
         .x(opnd_r[LW-1:0]), .y({LW{1'b0}}),
         .code_s(lane[g].tstz), .code_u(tstz_u_unused)
      );

      cc_arith_unit #(.W(LW)) u_arith (
         .a(opnd_a[LW-1:0]), .b(opnd_b[LW-1:0]), .r(opnd_r[LW-1:0]),
         .add_s(lane[g].add_s), .add_u(lane[g].add_u),
         .sub_s(lane[g].sub_s), .sub_u(lane[g].sub_u)
      );

      cc_unary_unit #(.W(LW)) u_unary (
         .r(opnd_r[LW-1:0]),
         .abs_v(lane[g].abs_v), .nabs_v(lane[g].nabs_v), .neg_v(lane[g].neg_v)
      );
   end

   logic [1:0] cc_d;
   logic       ill_d;
   logic [1:0] nz_code;

   assign nz_code = (|opnd_r) ? 2'd1 : 2'd0;

   always_comb begin
      cc_d  = 2'd0;
      ill_d = 1'b0;
      if (op <= OP_W'(CC_SEL_PASS_LAST)) begin
         cc_d = op[1:0];
      end else begin
         case (op)
            OP_W'(CC_SEL_TSTZ_N): cc_d = lane[0].tstz;
            OP_W'(CC_SEL_TSTZ_F): cc_d = lane[1].tstz;
            OP_W'(CC_SEL_CMPS_N): cc_d = lane[0].cmp_s;
            OP_W'(CC_SEL_CMPS_F): cc_d = lane[1].cmp_s;
            OP_W'(CC_SEL_CMPU_N): cc_d = lane[0].cmp_u;
            OP_W'(CC_SEL_CMPU_F): cc_d = lane[1].cmp_u;
            OP_W'(CC_SEL_NZ):     cc_d = nz_code;
            OP_W'(CC_SEL_ADDS_N): cc_d = lane[0].add_s;
            OP_W'(CC_SEL_ADDS_F): cc_d = lane[1].add_s;
            OP_W'(CC_SEL_ADDU_N): cc_d = lane[0].add_u;
            OP_W'(CC_SEL_ADDU_F): cc_d = lane[1].add_u;
            OP_W'(CC_SEL_SUBS_N): cc_d = lane[0].sub_s;
            OP_W'(CC_SEL_SUBS_F): cc_d = lane[1].sub_s;
            OP_W'(CC_SEL_SUBU_N): cc_d = lane[0].sub_u;
            OP_W'(CC_SEL_SUBU_F): cc_d = lane[1].sub_u;
            OP_W'(CC_SEL_ABS_N):  cc_d = lane[0].abs_v;
            OP_W'(CC_SEL_ABS_F):  cc_d = lane[1].abs_v;
            OP_W'(CC_SEL_NABS_N): cc_d = lane[0].nabs_v;
            OP_W'(CC_SEL_NABS_F): cc_d = lane[1].nabs_v;
            OP_W'(CC_SEL_NEG_N):  cc_d = lane[0].neg_v;
            OP_W'(CC_SEL_NEG_F):  cc_d = lane[1].neg_v;
            default:              ill_d = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cc      <= 2'd0;
         illegal <= 1'b0;
      end else if (in_valid) begin
         cc      <= cc_d;
         illegal <= ill_d;
      end
   end

   // R1
   pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op <= OP_W'(CC_SEL_PASS_LAST)) |=> (cc == $past(op[1:0]) && !illegal));

   // R12
   bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op > OP_W'(CC_SEL_LAST)) |=> (illegal && cc == 2'd0));

   // R12
   good_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op <= OP_W'(CC_SEL_LAST)) |=> !illegal);

   // R13
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(cc) && $stable(illegal)));
endmodule

// File: tb/tb_cc_gen.sv
module tb_cc_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  op = '0;
   logic [63:0] opnd_a = '0, opnd_b = '0, opnd_r = '0;
   logic [1:0]  cc;
   logic        illegal;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   cc_gen #(.DATA_W(64), .OP_W(5)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_r(opnd_r),
      .cc(cc), .illegal(illegal)
   );

   function automatic logic [1:0] sc(longint v);
      if (v == 0) return 2'd0;
      if (v < 0)  return 2'd1;
      return 2'd2;
   endfunction

   function automatic logic [1:0] ordc(logic lt, logic eq);
      if (eq) return 2'd0;
      return lt ? 2'd1 : 2'd2;
   endfunction

   // returns {illegal, code}
   function automatic logic [2:0] model(int s, logic [63:0] a, logic [63:0] b, logic [63:0] r);
      bit narrow;
      longint sa, sb, sr;
      logic [63:0] ua, ub, ur;
      bit rmin;
      narrow = (s < 10) ? (s % 2 == 0) : (s % 2 == 1);
      sa = narrow ? longint'($signed(a[31:0])) : $signed(a);
      sb = narrow ? longint'($signed(b[31:0])) : $signed(b);
      sr = narrow ? longint'($signed(r[31:0])) : $signed(r);
      ua = narrow ? {32'd0, a[31:0]} : a;
      ub = narrow ? {32'd0, b[31:0]} : b;
      ur = narrow ? {32'd0, r[31:0]} : r;
      rmin = narrow ? (r[31:0] == 32'h8000_0000) : (r == 64'h8000_0000_0000_0000);
      if (s <= 3) return {1'b0, 2'(s)};
      case (s)
         4, 5:   return {1'b0, sc(sr)};
         6, 7:   return {1'b0, ordc(sa < sb, sa == sb)};
         8, 9:   return {1'b0, ordc(ua < ub, ua == ub)};
         10:     return {1'b0, 1'b0, r != 0};
         11, 12: return ((sa > 0 && sb > 0 && sr < 0) || (sa < 0 && sb < 0 && sr > 0)) ? 3'd3 : {1'b0, sc(sr)};
         15, 16: return ((sa > 0 && sb < 0 && sr < 0) || (sa < 0 && sb > 0 && sr > 0)) ? 3'd3 : {1'b0, sc(sr)};
         13, 14: return {1'b0, (ur < ua) || (ur < ub), ur != 0};
         17, 18: return {1'b0, ua >= ub, ur != 0};
         19, 20: return rmin ? 3'd3 : (sr == 0 ? 3'd0 : 3'd2);
         21, 22: return (sr == 0) ? 3'd0 : 3'd1;
         23, 24: return rmin ? 3'd3 : {1'b0, sc(sr)};
         default: return 3'b100;
      endcase
   endfunction

   function automatic string tag(int s);
      if (s <= 3) return "R1";
      case (s)
         4, 5: return "R3";
         6, 7, 8, 9: return "R2";
         10: return "R4";
         11, 12: return "R5";
         15, 16: return "R6";
         13, 14: return "R7";
         17, 18: return "R8";
         19, 20, 21, 22: return "R9";
         23, 24: return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic check(string t, logic [2:0] exp_v);
      checks++;
      if ({illegal, cc} !== exp_v) begin
         errors++;
         $display("FAIL %s op=%0d actual=%b expected=%b", t, op, {illegal, cc}, exp_v);
      end
   endtask

   task automatic apply(int s, logic [63:0] a, logic [63:0] b, logic [63:0] r, string t);
      @(negedge clk);
      in_valid = 1'b1; op = 5'(s); opnd_a = a; opnd_b = b; opnd_r = r;
      @(negedge clk);
      in_valid = 1'b0;
      check(t, model(s, a, b, r));
   endtask

   function automatic logic [63:0] pick();
      case ($urandom % 10)
         0: return 64'd0;
         1: return 64'h8000_0000_0000_0000;
         2: return 64'h7FFF_FFFF_FFFF_FFFF;
         3: return '1;
         4: return {$urandom, 32'h8000_0000};
         5: return {$urandom, 32'h7FFF_FFFF};
         6: return {$urandom, 32'd0};
         7: return 64'd1;
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      #800000;
      errors++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      #10;
      @(negedge clk);
      check("R13 reset", 3'b000);
      rst_n = 1'b1;

      apply(2, '1, '1, '1, "R1");
      apply(3, 0, 0, 0, "R1");
      apply(12, 64'h7FFF_FFFF_FFFF_FFFF, 1, 64'h8000_0000_0000_0000, "R5");
      apply(11, 64'hFFFF_FFFF_7FFF_FFFF, 1, 64'h0000_0000_8000_0000, "R11");
      apply(16, 64'h8000_0000_0000_0000, 1, 64'h7FFF_FFFF_FFFF_FFFF, "R6");
      apply(14, '1, 1, 0, "R7");
      apply(17, 64'hAAAA_0000_0000_0005, 64'h5, 0, "R8");
      apply(19, 0, 0, 64'h1234_5678_8000_0000, "R11");
      apply(20, 0, 0, 64'h8000_0000_0000_0000, "R9");
      apply(23, 0, 0, 64'hFFFF_FFFF_8000_0000, "R10");
      apply(6, 64'h0000_0000_FFFF_FFFF, 64'h1, 0, "R2");
      apply(5, 0, 0, '1, "R3");
      apply(10, 0, 0, 64'h1_0000_0000, "R4");
      apply(27, 1, 2, 3, "R12");
      apply(9, 5, 5, 0, "R12");

      // hold while strobe low
      apply(24, 0, 0, 64'h8000_0000_0000_0000, "R10");
      @(negedge clk);
      op = 5'd31; opnd_r = 0;
      @(negedge clk);
      @(negedge clk);
      check("R13 hold", 3'b011);

      for (int i = 0; i < 3000; i++) begin
         int s;
         logic [63:0] a, b, r;
         s = int'($urandom % 32);
         a = pick();
         b = ($urandom % 6 == 0) ? a : pick();
         case ($urandom % 3)
            0: r = (s == 15 || s == 16 || s == 17 || s == 18) ? a - b : a + b;
            1: r = pick();
            default: r = {$urandom, $urandom};
         endcase
         apply(s, a, b, r, tag(s));
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule